// File: doc/BRIEF.md
# Rule-Counting Category Vote Stage

This block takes the one-bit outcomes of a large grid of comparison units and turns them into a single class decision. The grid is organised as CATS categories. Each category holds RULES rules, and each rule is fed by UNITS unit bits. A rule fires only when all of its unit bits are high. The score of a category is the number of its rules that fire. A maximum search then picks the category with the largest score. The block reports that category's index together with its score, so downstream software can form a certainty figure as score over RULES.

The unit grid arrives as one flat vector. All categories see it in the same cycle. An upstream stage raises `res_valid_i` when the unit bits are final. One clock later the block presents a registered decision and pulses `dec_valid_o` for one cycle. There is no back-pressure. The decision is a single-cycle pulse, and the registered index and score stay unchanged until the next accepted grid. A consumer that cannot take the pulse can still read the held values later.

Top module: `rule_vote_classifier`

## Requirements
- R1: A rule counts as active only if every one of its UNITS bits is 1; unit n of rule m in category k sits at bit index (k*RULES + m)*UNITS + n of `unit_bits_i`, and a rule with even one 0 bit adds nothing to its category's score.
- R2: A category's score equals the number of its active rules, a value from 0 to RULES, carried on `win_score_o` for the winning category.
- R3: `win_idx_o` is the index of the category with the strictly largest score.
- R4: When several categories share the largest score, the lowest index among them is reported.
- R5: A grid sampled at a rising edge with `res_valid_i` high produces `dec_valid_o` high for exactly the next cycle; `dec_valid_o` is low in any cycle that does not follow an accepted grid.
- R6: While `res_valid_i` is low, `unit_bits_i` is ignored and `win_idx_o` and `win_score_o` keep their last decision.
- R7: While `rst_n` is low and after its release, until the first accepted grid, `dec_valid_o`, `win_idx_o` and `win_score_o` are all 0.
- R8: A grid of all ones gives index 0 with score RULES, and a grid of all zeros gives index 0 with score 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Unit bits are final this cycle |
| unit_bits_i | input | CATS*RULES*UNITS | Flat grid of unit outcomes |
| dec_valid_o | output | 1 | One-cycle pulse marking a new decision |
| win_idx_o | output | index_bits(CATS) | Winning category index |
| win_score_o | output | score_bits(RULES) | Number of active rules in the winning category |

## Verification
The assertions assume that `res_valid_i` is a known level at every sampled edge once reset is released, and that `unit_bits_i` holds a known value whenever it is qualified by that strobe. The stimulus meets this assumption. It drives every input on the falling edge, starts from a fully defined zero grid during reset, and only ever loads fully built grids. The random phase mixes qualified and unqualified cycles, including back-to-back strobes. While the strobe is low it keeps changing the grid, so that hold behaviour is exercised by data that would alter the result if it were sampled. Directed grids cover partial rules, tied maxima and a winner in the last category.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  // Width of a count that ranges over 0..rules inclusive.
  function automatic int score_bits(input int rules);
    return (rules < 1) ? 1 : $clog2(rules + 1);
  endfunction

  // Width of an index over cats categories, at least one bit.
  function automatic int index_bits(input int cats);
    return (cats < 2) ? 1 : $clog2(cats);
  endfunction
endpackage

// File: rtl/rvc_rule_bank.sv
module rvc_rule_bank #(
  parameter int RULES = 20,
  parameter int UNITS = 6
) (
  input  logic [RULES*UNITS-1:0] rule_bits_i,
  output logic [RULES-1:0]       rule_hit_o
);
  // One wide AND per rule across its unit bits.
  for (genvar m = 0; m < RULES; m++) begin : g_rule
    assign rule_hit_o[m] = &rule_bits_i[m*UNITS +: UNITS];
  end
endmodule

// File: rtl/rvc_vote_counter.sv
module rvc_vote_counter #(
  parameter int RULES = 20,
  localparam int SW = rvc_pkg::score_bits(RULES)
) (
  input  logic [RULES-1:0] hit_i,
  output logic [SW-1:0]    score_o
);
  always_comb begin
    score_o = '0;
    for (int i = 0; i < RULES; i++) begin
      score_o = score_o + SW'(hit_i[i]);
    end
  end
endmodule

// File: rtl/rvc_max_tree.sv
module rvc_max_tree #(
  parameter int CATS  = 5,
  parameter int RULES = 20,
  localparam int SW    = rvc_pkg::score_bits(RULES),
  localparam int IW    = rvc_pkg::index_bits(CATS),
  localparam int LEAVES = 1 << $clog2(CATS),
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic [CATS*SW-1:0] scores_i,
  output logic [IW-1:0]      win_idx_o,
  output logic [SW-1:0]      win_score_o
);
  // Heap layout: node i has children 2i+1 (lower indices) and 2i+2.
  logic [SW-1:0] node_score [NODES];
  logic [IW-1:0] node_idx   [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < CATS) begin : g_real
      assign node_score[LEAVES-1+j] = scores_i[j*SW +: SW];
      assign node_idx[LEAVES-1+j]   = IW'(j);
    end else begin : g_pad
      // Padding sits on the right and can never beat a real score.
      assign node_score[LEAVES-1+j] = '0;
      assign node_idx[LEAVES-1+j]   = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic take_right;
    // Strict compare: equal scores keep the lower-index side.
    assign take_right    = node_score[2*i+2] > node_score[2*i+1];
    assign node_score[i] = take_right ? node_score[2*i+2] : node_score[2*i+1];
    assign node_idx[i]   = take_right ? node_idx[2*i+2]   : node_idx[2*i+1];
  end

  assign win_idx_o   = node_idx[0];
  assign win_score_o = node_score[0];
endmodule

// File: rtl/rule_vote_classifier.sv
module rule_vote_classifier #(
  parameter int CATS  = 5,
  parameter int RULES = 20,
  parameter int UNITS = 6,
  localparam int SW   = rvc_pkg::score_bits(RULES),
  localparam int IW   = rvc_pkg::index_bits(CATS),
  localparam int CATW = RULES * UNITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_valid_i,
  input  logic [CATS*RULES*UNITS-1:0] unit_bits_i,
  output logic                        dec_valid_o,
  output logic [IW-1:0]               win_idx_o,
  output logic [SW-1:0]               win_score_o
);
  logic [CATS*SW-1:0] cat_scores;
  logic [IW-1:0]      best_idx;
  logic [SW-1:0]      best_score;

  for (genvar k = 0; k < CATS; k++) begin : g_cat
    logic [RULES-1:0] hits;

    rvc_rule_bank #(.RULES(RULES), .UNITS(UNITS)) u_bank (
      .rule_bits_i (unit_bits_i[k*CATW +: CATW]),
      .rule_hit_o  (hits)
    );

    rvc_vote_counter #(.RULES(RULES)) u_count (
      .hit_i   (hits),
      .score_o (cat_scores[k*SW +: SW])
    );
  end

  rvc_max_tree #(.CATS(CATS), .RULES(RULES)) u_max (
    .scores_i    (cat_scores),
    .win_idx_o   (best_idx),
    .win_score_o (best_score)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      win_idx_o   <= '0;
      win_score_o <= '0;
    end else begin
      dec_valid_o <= res_valid_i;
      if (res_valid_i) begin
        win_idx_o   <= best_idx;
        win_score_o <= best_score;
      end
    end
  end
endmodule

// File: rtl/rvc_checker.sv
module rvc_checker #(
  parameter int CATS  = 5,
  parameter int RULES = 20,
  parameter int UNITS = 6,
  localparam int SW   = rvc_pkg::score_bits(RULES),
  localparam int IW   = rvc_pkg::index_bits(CATS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        res_valid_i,
  input logic [CATS*RULES*UNITS-1:0] unit_bits_i,
  input logic                        dec_valid_o,
  input logic [IW-1:0]               win_idx_o,
  input logic [SW-1:0]               win_score_o
);
  assert_pulse_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> dec_valid_o);

  assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> !dec_valid_o);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> ($stable(win_idx_o) && $stable(win_score_o)));

  assert_score_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> ({1'b0, win_score_o} <= (SW+1)'(RULES)));

  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> ({1'b0, win_idx_o} < (IW+1)'(CATS)));

  assert_full_grid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && (&unit_bits_i)) |=>
      (win_idx_o == '0 && win_score_o == SW'(RULES)));

  // Every category scores zero, so the lowest index must win the tie (R4).
  assert_empty_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && (unit_bits_i == '0)) |=>
      (win_idx_o == '0 && win_score_o == '0));
endmodule

bind rule_vote_classifier rvc_checker #(
  .CATS(CATS), .RULES(RULES), .UNITS(UNITS)
) u_rvc_checker (.*);

// File: tb/rule_vote_classifier_bench.sv
module rule_vote_classifier_bench;
  localparam int CATS  = 5;
  localparam int RULES = 20;
  localparam int UNITS = 6;
  localparam int W     = CATS * RULES * UNITS;
  localparam int SW    = rvc_pkg::score_bits(RULES);
  localparam int IW    = rvc_pkg::index_bits(CATS);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          res_valid_i;
  logic [W-1:0]  unit_bits_i;
  logic          dec_valid_o;
  logic [IW-1:0] win_idx_o;
  logic [SW-1:0] win_score_o;

  rule_vote_classifier #(.CATS(CATS), .RULES(RULES), .UNITS(UNITS)) u_rule_vote_classifier (
    .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid_i), .unit_bits_i(unit_bits_i),
    .dec_valid_o(dec_valid_o), .win_idx_o(win_idx_o), .win_score_o(win_score_o)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  bit    exp_valid = 0;
  int    exp_idx = 0;
  int    exp_score = 0;
  string exp_ctx = "R7";

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference: count fully-set rules per category, strict argmax.
  task automatic ref_eval(input logic [W-1:0] g, output int idx, output int sc, output bit tie);
    int best = -1;
    idx = 0; tie = 0;
    for (int k = 0; k < CATS; k++) begin
      int cnt = 0;
      for (int m = 0; m < RULES; m++) begin
        bit all_set = 1;
        for (int n = 0; n < UNITS; n++)
          if (!g[(k*RULES + m)*UNITS + n]) all_set = 0;
        if (all_set) cnt++;
      end
      if (cnt > best) begin best = cnt; idx = k; tie = 0; end
      else if (cnt == best) tie = 1;
    end
    sc = best;
  endtask

  function automatic logic [W-1:0] make_grid(input int tgt [CATS], input bit exact);
    logic [W-1:0] g = '0;
    for (int k = 0; k < CATS; k++) begin
      for (int m = 0; m < RULES; m++) begin
        bit on = exact ? (m < tgt[k]) : ($urandom_range(0, RULES-1) < tgt[k]);
        for (int n = 0; n < UNITS; n++)
          g[(k*RULES + m)*UNITS + n] = on ? 1'b1 : 1'($urandom_range(0, 1));
        if (!on) g[(k*RULES + m)*UNITS + $urandom_range(0, UNITS-1)] = 1'b0;
      end
    end
    return g;
  endfunction

  task automatic compare();
    chk("R5", "dec_valid", int'(dec_valid_o), int'(exp_valid));
    chk(exp_valid ? exp_ctx : "R6", "win_idx", int'(win_idx_o), exp_idx);
    chk(exp_valid ? exp_ctx : "R6", "win_score", int'(win_score_o), exp_score);
  endtask

  task automatic step(input bit v, input logic [W-1:0] g, input string ctx);
    int i; int s; bit t;
    @(negedge clk);
    compare();
    res_valid_i = v;
    unit_bits_i = g;
    if (v) begin
      ref_eval(g, i, s, t);
      exp_idx   = i;
      exp_score = s;
      exp_ctx   = (t && ctx == "R2 R3") ? "R4" : ctx;
      exp_valid = 1;
    end else begin
      exp_valid = 0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    logic [W-1:0] g;
    int t [CATS];
    rst_n = 0; res_valid_i = 0; unit_bits_i = '0;
    repeat (3) @(negedge clk);
    chk("R7", "dec_valid in reset", int'(dec_valid_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R7", "dec_valid after reset", int'(dec_valid_o), 0);
    chk("R7", "win_idx after reset", int'(win_idx_o), 0);
    chk("R7", "win_score after reset", int'(win_score_o), 0);

    // R8: extreme grids
    step(1, '1, "R8");
    step(1, '0, "R8");

    // R1: near-complete rules must not count
    t = '{3, 0, 0, 0, 0};
    step(1, make_grid(t, 1), "R1");
    g = '0;
    for (int m = 0; m < RULES; m++)
      for (int n = 0; n < UNITS - 1; n++) g[(3*RULES + m)*UNITS + n] = 1'b1;
    for (int n = 0; n < UNITS; n++) g[(2*RULES + 7)*UNITS + n] = 1'b1;
    step(1, g, "R1");

    // R4: ties go to the lowest index
    t = '{4, 9, 2, 9, 9};
    step(1, make_grid(t, 1), "R4");
    t = '{7, 7, 7, 7, 7};
    step(1, make_grid(t, 1), "R4");
    // R3: winner in the last category
    t = '{0, 0, 0, 0, 12};
    step(1, make_grid(t, 1), "R3");

    // R6: unqualified grids must not move the outputs
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < CATS; k++) t[k] = $urandom_range(0, RULES);
      step(0, make_grid(t, 1), "R6");
    end
    step(0, '1, "R6");

    // R2 R3 R5: random mix of qualified and idle cycles
    for (int c = 0; c < 400; c++) begin
      for (int k = 0; k < CATS; k++) t[k] = $urandom_range(0, RULES);
      step($urandom_range(0, 99) < 60, make_grid(t, c[0]), "R2 R3");
    end

    step(0, '0, "R6");
    @(negedge clk);
    compare();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule